// File: doc/BRIEF.md
# Buffer Address and Range Checker

This block turns one lane's buffer-access request into a byte address. The request carries the descriptor fields, the instruction flags and the per-lane operand values. The block also decides whether the access falls outside the buffer. It picks the record index and the in-record offset from the lane's vector operands. It then forms a buffer offset in one of two ways: plain record layout, or an interleaved scratch layout built from an encoded element size and index stride. Finally it adds the descriptor base and the scalar offset.

A separate wide mode takes a full 64-bit address from two vector operands and does no bounds check. Flags that travel with the address report whether the request is out of range, whether a 32-bit access is misaligned, and whether the flag combination is illegal. A write enable and a zero-fill indication are also produced, so that out-of-range stores are dropped and out-of-range loads return zero.

The datapath has two register stages and accepts one request per cycle.

Top module: `buf_addr_unit`

## Requirements
- R1: The effective index is (vreg0 if op_idxen else 0) plus (lane_id if desc_tid else 0). The effective offset is op_imm plus, when op_offen is set, vreg1 if op_idxen is also set and vreg0 otherwise. Both sums wrap at 32 bits.
- R2: With desc_swz clear, the buffer offset is the low 32 bits of index×stride plus the effective offset, modulo 2^32.
- R3: With desc_swz set, let E = 2<<desc_esz and S = 8<<desc_isz. The buffer offset is off%E + E×(idx%S) + S×((idx/S)×stride + (off/E)×E), modulo 2^32.
- R4: With op_wide clear, out_addr = desc_base + sreg_off + buffer offset, modulo 2^64.
- R5: With op_wide set, out_addr = desc_base + {vreg1,vreg0} + op_imm + sreg_off, modulo 2^64, and out_oor is 0.
- R6: With stride 0 and op_wide clear, out_oor is 1 exactly when the buffer offset is at least (desc_nrec − sreg_off) mod 2^32.
- R7: With stride nonzero, op_wide clear, and op_idxen or desc_tid set, out_oor is 1 when the index is at least desc_nrec or the effective offset is at least the stride.
- R8: With stride nonzero and both op_idxen and desc_tid clear, out_oor is 0 whatever the offset.
- R9: out_misalign is 1 exactly when op_dword is set and out_addr[1:0] is nonzero.
- R10: out_illegal is 1 exactly when op_wide is set together with op_offen or op_idxen.
- R11: out_wr_en = op_store AND NOT out_oor. out_zero_fill = NOT op_store AND out_oor.
- R12: out_valid rises two clock edges after in_valid. All flags are 0 while out_valid is 0 and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| desc_base | input | 48 | Buffer base address |
| desc_stride | input | 14 | Record size in bytes |
| desc_nrec | input | 32 | Record count / byte limit |
| desc_swz | input | 1 | Interleaved scratch layout enable |
| desc_esz | input | 2 | Element size code |
| desc_isz | input | 2 | Index stride code |
| desc_tid | input | 1 | Add lane id to index |
| op_imm | input | IMM_W | Immediate offset |
| op_offen | input | 1 | Use vector offset |
| op_idxen | input | 1 | Use vector index |
| op_wide | input | 1 | 64-bit unchecked address mode |
| op_dword | input | 1 | 32-bit access size |
| op_store | input | 1 | Access is a write |
| vreg0 | input | 32 | First vector operand |
| vreg1 | input | 32 | Second vector operand |
| sreg_off | input | 32 | Scalar offset |
| lane_id | input | LANE_W | Lane number |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Byte address |
| out_oor | output | 1 | Out of range |
| out_misalign | output | 1 | 32-bit access not 4-byte aligned |
| out_illegal | output | 1 | Wide mode combined with index/offset flags |
| out_wr_en | output | 1 | Store may proceed |
| out_zero_fill | output | 1 | Load returns zero |

## Verification
The bench uses the defaults: IMM_W=12, LANE_W=6 and swizzle support built in. These keep the lane-id term and immediate small, so that random index and offset values land right at the record-count and stride limits. Record counts and strides are drawn from narrow ranges, and stride 0 is given a heavy weight, so both range rules and both sides of each limit are hit often. Swizzle cases sweep all four element-size and index-stride codes, and wide-mode cases carry carries across the 32-bit boundary of the address.

// File: rtl/buf_addr_pkg.sv
package buf_addr_pkg;
  localparam int BASE_W   = 48;
  localparam int STRIDE_W = 14;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 64;

  // Record-layout offset: idx*stride truncated, plus offset.
  function automatic logic [WORD_W-1:0] lin_offset(
    input logic [WORD_W-1:0]   idx,
    input logic [STRIDE_W-1:0] stride,
    input logic [WORD_W-1:0]   off);
    logic [WORD_W-1:0] prod;
    prod = idx * {{(WORD_W-STRIDE_W){1'b0}}, stride};
    return prod + off;
  endfunction

  // Interleaved layout: element and index stride are powers of two.
  function automatic logic [WORD_W-1:0] swz_offset(
    input logic [WORD_W-1:0]   idx,
    input logic [STRIDE_W-1:0] stride,
    input logic [WORD_W-1:0]   off,
    input logic [1:0]          esz,
    input logic [1:0]          isz);
    logic [4:0]        es_sh, is_sh;
    logic [WORD_W-1:0] es_msk, is_msk, lo, mid, hi;
    es_sh  = {3'b0, esz} + 5'd1;
    is_sh  = {3'b0, isz} + 5'd3;
    es_msk = (32'd1 << es_sh) - 32'd1;
    is_msk = (32'd1 << is_sh) - 32'd1;
    lo  = off & es_msk;
    mid = (idx & is_msk) << es_sh;
    hi  = ((idx >> is_sh) * {{(WORD_W-STRIDE_W){1'b0}}, stride})
        + ((off >> es_sh) << es_sh);
    return lo + mid + (hi << is_sh);
  endfunction

  // Bounds rule selected by stride.
  function automatic logic range_fail(
    input logic [WORD_W-1:0]   boff,
    input logic [WORD_W-1:0]   idx,
    input logic [WORD_W-1:0]   off,
    input logic [WORD_W-1:0]   nrec,
    input logic [WORD_W-1:0]   soff,
    input logic [STRIDE_W-1:0] stride,
    input logic                indexed);
    logic r;
    if (stride == '0)
      r = (boff >= (nrec - soff));
    else if (indexed)
      r = (idx >= nrec) || (off >= {{(WORD_W-STRIDE_W){1'b0}}, stride});
    else
      r = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/bau_operand_sel.sv
module bau_operand_sel
  import buf_addr_pkg::*;
(
  input  logic [WORD_W-1:0] vreg0,
  input  logic [WORD_W-1:0] vreg1,
  input  logic              offen,
  input  logic              idxen,
  input  logic              tid,
  input  logic [WORD_W-1:0] imm32,
  input  logic [WORD_W-1:0] lane32,
  output logic [WORD_W-1:0] eff_idx,
  output logic [WORD_W-1:0] eff_off
);
  logic [WORD_W-1:0] off_src;

  always_comb begin
    off_src = idxen ? vreg1 : vreg0;
    eff_idx = (idxen ? vreg0 : '0) + (tid ? lane32 : '0);
    eff_off = imm32 + (offen ? off_src : '0);
  end
endmodule

// File: rtl/bau_offset_calc.sv
module bau_offset_calc
  import buf_addr_pkg::*;
#(
  parameter bit SWZ_EN = 1'b1
) (
  input  logic [WORD_W-1:0]   eff_idx,
  input  logic [WORD_W-1:0]   eff_off,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                swz,
  input  logic [1:0]          esz,
  input  logic [1:0]          isz,
  output logic [WORD_W-1:0]   boff
);
  logic [WORD_W-1:0] lin_v;

  assign lin_v = lin_offset(eff_idx, stride, eff_off);

  generate
    if (SWZ_EN) begin : g_swz
      logic [WORD_W-1:0] swz_v;
      assign swz_v = swz_offset(eff_idx, stride, eff_off, esz, isz);
      assign boff  = swz ? swz_v : lin_v;
    end else begin : g_lin
      logic unused_swz;
      assign unused_swz = swz ^ (^esz) ^ (^isz);
      assign boff = lin_v;
    end
  endgenerate
endmodule

// File: rtl/bau_range_chk.sv
module bau_range_chk
  import buf_addr_pkg::*;
(
  input  logic [WORD_W-1:0]   boff,
  input  logic [WORD_W-1:0]   eff_idx,
  input  logic [WORD_W-1:0]   eff_off,
  input  logic [WORD_W-1:0]   nrec,
  input  logic [WORD_W-1:0]   soff,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                indexed,
  input  logic                wide,
  output logic                oor
);
  assign oor = !wide && range_fail(boff, eff_idx, eff_off, nrec, soff, stride, indexed);
endmodule

// File: rtl/buf_addr_unit.sv
module buf_addr_unit
  import buf_addr_pkg::*;
#(
  parameter int IMM_W  = 12,
  parameter int LANE_W = 6,
  parameter bit SWZ_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [BASE_W-1:0]   desc_base,
  input  logic [STRIDE_W-1:0] desc_stride,
  input  logic [WORD_W-1:0]   desc_nrec,
  input  logic                desc_swz,
  input  logic [1:0]          desc_esz,
  input  logic [1:0]          desc_isz,
  input  logic                desc_tid,
  input  logic [IMM_W-1:0]    op_imm,
  input  logic                op_offen,
  input  logic                op_idxen,
  input  logic                op_wide,
  input  logic                op_dword,
  input  logic                op_store,
  input  logic [WORD_W-1:0]   vreg0,
  input  logic [WORD_W-1:0]   vreg1,
  input  logic [WORD_W-1:0]   sreg_off,
  input  logic [LANE_W-1:0]   lane_id,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  output logic                out_oor,
  output logic                out_misalign,
  output logic                out_illegal,
  output logic                out_wr_en,
  output logic                out_zero_fill
);
  localparam int IMM_PAD  = WORD_W - IMM_W;
  localparam int LANE_PAD = WORD_W - LANE_W;

  // ---------------- stage 1: operand selection ----------------
  logic [WORD_W-1:0] imm32, lane32, sel_idx, sel_off;
  assign imm32  = {{IMM_PAD{1'b0}}, op_imm};
  assign lane32 = {{LANE_PAD{1'b0}}, lane_id};

  bau_operand_sel u_sel (
    .vreg0(vreg0), .vreg1(vreg1), .offen(op_offen), .idxen(op_idxen),
    .tid(desc_tid), .imm32(imm32), .lane32(lane32),
    .eff_idx(sel_idx), .eff_off(sel_off)
  );

  logic                s1_valid, s1_swz, s1_wide, s1_dword, s1_store, s1_indexed, s1_illegal;
  logic [WORD_W-1:0]   s1_idx, s1_off, s1_nrec, s1_soff, s1_imm;
  logic [ADDR_W-1:0]   s1_vaddr;
  logic [BASE_W-1:0]   s1_base;
  logic [STRIDE_W-1:0] s1_stride;
  logic [1:0]          s1_esz, s1_isz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    s1_idx     <= sel_idx;
    s1_off     <= sel_off;
    s1_imm     <= imm32;
    s1_vaddr   <= {vreg1, vreg0};
    s1_base    <= desc_base;
    s1_stride  <= desc_stride;
    s1_nrec    <= desc_nrec;
    s1_soff    <= sreg_off;
    s1_swz     <= desc_swz;
    s1_esz     <= desc_esz;
    s1_isz     <= desc_isz;
    s1_wide    <= op_wide;
    s1_dword   <= op_dword;
    s1_store   <= op_store;
    s1_indexed <= op_idxen | desc_tid;
    s1_illegal <= op_wide & (op_offen | op_idxen);
  end

  // ---------------- stage 2: offset, range, address ----------------
  logic [WORD_W-1:0] s1_boff;
  logic              s1_oor;
  logic [ADDR_W-1:0] s1_addr, base64;

  bau_offset_calc #(.SWZ_EN(SWZ_EN)) u_off (
    .eff_idx(s1_idx), .eff_off(s1_off), .stride(s1_stride),
    .swz(s1_swz), .esz(s1_esz), .isz(s1_isz), .boff(s1_boff)
  );

  bau_range_chk u_rng (
    .boff(s1_boff), .eff_idx(s1_idx), .eff_off(s1_off), .nrec(s1_nrec),
    .soff(s1_soff), .stride(s1_stride), .indexed(s1_indexed),
    .wide(s1_wide), .oor(s1_oor)
  );

  assign base64 = {{(ADDR_W-BASE_W){1'b0}}, s1_base}
                + {{(ADDR_W-WORD_W){1'b0}}, s1_soff};

  always_comb begin
    if (s1_wide)
      s1_addr = base64 + s1_vaddr + {{(ADDR_W-WORD_W){1'b0}}, s1_imm};
    else
      s1_addr = base64 + {{(ADDR_W-WORD_W){1'b0}}, s1_boff};
  end

  // internal copies kept for assertions
  logic o_wide, o_dword, o_stride_nz, o_indexed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_oor       <= 1'b0;
      out_misalign  <= 1'b0;
      out_illegal   <= 1'b0;
      out_wr_en     <= 1'b0;
      out_zero_fill <= 1'b0;
      o_wide        <= 1'b0;
      o_dword       <= 1'b0;
      o_stride_nz   <= 1'b0;
      o_indexed     <= 1'b0;
    end else begin
      out_valid     <= s1_valid;
      out_oor       <= s1_valid & s1_oor;
      out_misalign  <= s1_valid & s1_dword & (s1_addr[1:0] != 2'b00);
      out_illegal   <= s1_valid & s1_illegal;
      out_wr_en     <= s1_valid & s1_store & ~s1_oor;
      out_zero_fill <= s1_valid & ~s1_store & s1_oor;
      o_wide        <= s1_wide;
      o_dword       <= s1_dword;
      o_stride_nz   <= (s1_stride != '0);
      o_indexed     <= s1_indexed;
    end
    out_addr <= s1_addr;
  end

  // ---------------- assertions ----------------
  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));
  assert_flags_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_oor | out_misalign | out_illegal | out_wr_en | out_zero_fill));
  assert_wide_unchecked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_wide) |-> !out_oor);
  assert_unindexed_inrange_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !o_wide && o_stride_nz && !o_indexed) |-> !out_oor);
  assert_illegal_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> o_wide);
  assert_misalign_dword_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_misalign |-> o_dword);
  assert_store_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> !out_oor);
  assert_zero_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero_fill |-> (out_oor && !out_wr_en));
endmodule

// File: tb/tb_buf_addr_unit.sv
module tb_buf_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [47:0] t_base = '0;
  logic [13:0] t_stride = '0;
  logic [31:0] t_nrec = '0;
  logic        t_swz = 1'b0;
  logic [1:0]  t_esz = '0, t_isz = '0;
  logic        t_tid = 1'b0;
  logic [11:0] t_imm = '0;
  logic        t_offen = 1'b0, t_idxen = 1'b0, t_wide = 1'b0, t_dword = 1'b0, t_store = 1'b0;
  logic [31:0] t_v0 = '0, t_v1 = '0, t_soff = '0;
  logic [5:0]  t_lane = '0;

  logic        out_valid, out_oor, out_misalign, out_illegal, out_wr_en, out_zero_fill;
  logic [63:0] out_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  buf_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .desc_base(t_base), .desc_stride(t_stride), .desc_nrec(t_nrec),
    .desc_swz(t_swz), .desc_esz(t_esz), .desc_isz(t_isz), .desc_tid(t_tid),
    .op_imm(t_imm), .op_offen(t_offen), .op_idxen(t_idxen), .op_wide(t_wide),
    .op_dword(t_dword), .op_store(t_store),
    .vreg0(t_v0), .vreg1(t_v1), .sreg_off(t_soff), .lane_id(t_lane),
    .out_valid(out_valid), .out_addr(out_addr), .out_oor(out_oor),
    .out_misalign(out_misalign), .out_illegal(out_illegal),
    .out_wr_en(out_wr_en), .out_zero_fill(out_zero_fill)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- reference model, written from the requirements ----
  logic [31:0] e_idx, e_off, e_boff, e_lim;
  logic [63:0] e_addr;
  logic        e_oor, e_mis, e_ill, e_wr, e_zero;

  task automatic model();
    longint unsigned es, is_, o, x, t;
    e_idx = (t_idxen ? t_v0 : 32'd0) + (t_tid ? {26'd0, t_lane} : 32'd0);
    e_off = {20'd0, t_imm} + (t_offen ? (t_idxen ? t_v1 : t_v0) : 32'd0);
    if (t_swz) begin
      es = 64'd2 << t_esz;
      is_ = 64'd8 << t_isz;
      o = e_off; x = e_idx;
      t = (o % es) + es * (x % is_) + is_ * ((x / is_) * t_stride + (o / es) * es);
      e_boff = t[31:0];
    end else begin
      t = longint'(e_idx) * longint'(t_stride);
      e_boff = t[31:0] + e_off;
    end
    if (t_wide)
      e_addr = {16'd0, t_base} + {t_v1, t_v0} + {52'd0, t_imm} + {32'd0, t_soff};
    else
      e_addr = {16'd0, t_base} + {32'd0, t_soff} + {32'd0, e_boff};
    e_lim = t_nrec - t_soff;
    if (t_wide) e_oor = 1'b0;
    else if (t_stride == 0) e_oor = (e_boff >= e_lim);
    else if (t_idxen || t_tid) e_oor = (e_idx >= t_nrec) || (e_off >= {18'd0, t_stride});
    else e_oor = 1'b0;
    e_mis  = t_dword && (e_addr % 4 != 0);
    e_ill  = t_wide && (t_offen || t_idxen);
    e_wr   = t_store && !e_oor;
    e_zero = !t_store && e_oor;
  endtask

  task automatic go(input string tag);
    model();
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, {"R12 valid ", tag}, {63'd0, out_valid}, 64'd1);
    chk(out_addr == e_addr, {(t_wide ? "R5 addr " : (t_swz ? "R3/R4 addr " : "R2/R4 addr ")), tag}, out_addr, e_addr);
    chk(out_oor == e_oor, {(t_wide ? "R5 oor " : (t_stride == 0 ? "R6 oor " :
        ((t_idxen || t_tid) ? "R7 oor " : "R8 oor "))), tag}, {63'd0, out_oor}, {63'd0, e_oor});
    chk(out_misalign == e_mis, {"R9 misalign ", tag}, {63'd0, out_misalign}, {63'd0, e_mis});
    chk(out_illegal == e_ill, {"R10 illegal ", tag}, {63'd0, out_illegal}, {63'd0, e_ill});
    chk(out_wr_en == e_wr && out_zero_fill == e_zero, {"R11 wr/zero ", tag},
        {62'd0, out_wr_en, out_zero_fill}, {62'd0, e_wr, e_zero});
    @(negedge clk);
    chk(out_valid == 1'b0 && out_oor == 1'b0, {"R12 idle ", tag}, {62'd0, out_valid, out_oor}, 64'd0);
  endtask

  task automatic clear_req();
    t_base = 48'h1000; t_stride = 0; t_nrec = 0; t_swz = 0; t_esz = 0; t_isz = 0;
    t_tid = 0; t_imm = 0; t_offen = 0; t_idxen = 0; t_wide = 0; t_dword = 0;
    t_store = 0; t_v0 = 0; t_v1 = 0; t_soff = 0; t_lane = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    clear_req();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_oor == 0 && out_wr_en == 0 && out_zero_fill == 0 && out_illegal == 0,
        "R12 reset state", {59'd0, out_valid, out_oor, out_wr_en, out_zero_fill, out_illegal}, 64'd0);

    // R6 boundary: limit = 100-20 = 80
    clear_req(); t_nrec = 100; t_soff = 20; t_offen = 1; t_v0 = 79; go("R6 just inside");
    t_v0 = 80; go("R6 at limit");
    t_store = 1; go("R11 store dropped");
    // R7 index and offset limits, R1 V/V+1 selection
    clear_req(); t_stride = 16; t_nrec = 10; t_idxen = 1; t_v0 = 9; go("R7 index last");
    t_v0 = 10; go("R7 index over");
    t_v0 = 3; t_offen = 1; t_v1 = 15; t_store = 1; go("R1 offset from V+1");
    t_v1 = 16; go("R7 offset at stride");
    // R8 unindexed, large offset ignored by range
    clear_req(); t_stride = 16; t_nrec = 1; t_offen = 1; t_v0 = 32'h0000_FFF0; go("R8 no index");
    // R1 lane id term
    clear_req(); t_stride = 8; t_nrec = 64; t_tid = 1; t_lane = 6'd63; t_idxen = 1; t_v0 = 1; go("R1 lane add");
    // R3 swizzle fixed case: ES=4, IS=8, idx 10, off 6 -> 170
    clear_req(); t_swz = 1; t_esz = 1; t_isz = 0; t_stride = 16; t_nrec = 1000;
    t_idxen = 1; t_offen = 1; t_v0 = 10; t_v1 = 6; go("R3 fixed");
    chk(e_boff == 32'd170, "R3 bench model self-consistency", {32'd0, e_boff}, 64'd170);
    // R5/R10 wide mode
    clear_req(); t_wide = 1; t_v0 = 32'hFFFF_FFF0; t_v1 = 32'h1; t_imm = 12'h20; t_soff = 4; go("R5 carry");
    t_offen = 1; go("R10 wide+offen");
    // R9 misaligned dword
    clear_req(); t_nrec = 32'hFFFF_FFFF; t_dword = 1; t_imm = 12'h2; go("R9 misaligned");
    t_imm = 12'h4; go("R9 aligned");

    for (int i = 0; i < 500; i++) begin
      t_base   = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      t_stride = ($urandom % 3 == 0) ? 14'd0 : 14'($urandom % 64);
      t_nrec   = ($urandom % 2) ? ($urandom % 256) : $urandom;
      t_swz    = 1'($urandom);
      t_esz    = 2'($urandom); t_isz = 2'($urandom);
      t_tid    = 1'($urandom);
      t_imm    = 12'($urandom);
      t_wide   = ($urandom % 5 == 0);
      t_offen  = 1'($urandom); t_idxen = 1'($urandom);
      t_dword  = 1'($urandom); t_store = 1'($urandom);
      t_v0     = ($urandom % 2) ? ($urandom % 300) : $urandom;
      t_v1     = ($urandom % 2) ? ($urandom % 300) : $urandom;
      t_soff   = ($urandom % 2) ? ($urandom % 64) : $urandom;
      t_lane   = 6'($urandom);
      go("random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule